// File: doc/BRIEF.md
# Byte-Wide SPI Master

This block is a register-mapped SPI master that shifts exactly one 8-bit frame each time software issues a start command. It keeps no data FIFO. It holds a single transmit byte and a single receive byte, and raises one interrupt line when a frame has finished. Software sets the serial clock rate with a divisor. It also selects clock polarity, phase and bit order, and can turn on an internal loopback that feeds the outgoing serial data back into the receiver in place of MISO.

A typical driver works like this. It sets the mode and divisor, writes the outgoing byte, and writes the start bit. It then waits for the interrupt, reads the received byte to clear it, and repeats. Chip selects are generated outside the block. The serial clock runs at the bus clock divided by 4×(divisor+1).

The phase control has the opposite sense to the usual CPHA flag. When it is set, data is captured on the leading SCK edge. When it is clear, data is captured on the trailing edge. At the end of a frame, the busy flag stays up for one extra bus clock after the ready flag and the interrupt have been raised.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every register reads 0x00, and SCK, MOSI and the interrupt are low.
- R2: The register offsets are: 0 mode, 1 receive data, 2 transmit data, 3 control, 4 status, 6 divisor. Mode, transmit and divisor read back what was written, using mode bits 4:0. Control and offset 5 read 0x00. Status bit 1 is busy and bit 0 is receive-ready.
- R3: Writing 0x01 to offset 3 while the port is enabled and idle produces exactly one frame of 8 SCK cycles (16 SCK transitions).
- R4: SCK idles at the level of mode bit 0x02. While a frame runs, the SCK period is 4×(divisor+1) bus clocks.
- R5: With mode bit 0x10 set, MISO and MOSI are captured on leading SCK edges and MOSI changes on trailing edges. With 0x10 clear, the roles of the two edges are swapped.
- R6: With mode bit 0x04 clear, the frame is sent and received MSB first. With 0x04 set, it is sent and received LSB first, and in both cases the received byte reads back in its natural bit order.
- R7: With mode bit 0x01 set, the received byte equals the transmitted byte regardless of MISO.
- R8: Receive-ready and the interrupt rise on the clock after the last SCK edge. Busy stays set for exactly one more clock, so status reads 0x03 and then 0x01.
- R9: A read of offset 1 clears receive-ready and the interrupt. When that read falls in the same cycle as a frame completion, ready stays set and the new byte is kept.
- R10: A start issued while busy is ignored. A transmit write during a frame does not alter the frame in flight and is sent by the next start.
- R11: While mode bit 0x08 (enable) is clear, SCK holds its idle level, MOSI is low and starts are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect on offset 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt, high while a received byte waits |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The race that matters is a receive-data read landing in the same bus clock as a frame completion. One function clears receive-ready and the other sets it. The bench counts 16 half-periods of 2×(divisor+1) clocks from the accepted start, places the read strobe exactly on the completing edge, and then requires that ready is still set, that status shows busy's tail, and that a second read returns the byte that just finished. In the same frame it issues a second start and a new transmit byte. The bench then checks that no extra frame follows and that the next start sends the new byte.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

  localparam int BYTE_W = 8;

  // register byte offsets
  localparam int OFS_MODE = 0;
  localparam int OFS_RXD  = 1;
  localparam int OFS_TXD  = 2;
  localparam int OFS_CTRL = 3;
  localparam int OFS_STAT = 4;
  localparam int OFS_DIV  = 6;

  // mode register layout, MSB to LSB: 0x10 0x08 0x04 0x02 0x01
  typedef struct packed {
    logic lead_cap;  // capture on leading edge (inverse of CPHA)
    logic en;        // port enable
    logic lsb;       // LSB first
    logic idle_hi;   // clock idles high
    logic loop;      // internal loopback
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/spi_byte_prescale.sv
module spi_byte_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // half period is 2*(div+1) clocks, so the terminal count is 2*div+1
  assign limit = {div, 1'b1};
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_byte_pkg::*;
#(
  parameter int BITS  = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [BITS-1:0]  tx_byte,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [BITS-1:0]  rx_word
);
  localparam int EDGES = 2 * BITS;
  localparam int IDX_W = $clog2(EDGES);
  localparam logic [IDX_W-1:0] LAST_EDGE = IDX_W'(EDGES - 1);

  logic             shifting, tail, tog, mosi_q;
  logic [IDX_W-1:0] edge_idx;
  logic [BITS-1:0]  txs, rxs, rx_next, tx_rev, rx_rev, ld;
  logic             tick, accept, leading, sample_now, launch_now, bit_in;

  spi_byte_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (shifting),
    .div  (div),
    .tick (tick)
  );

  for (genvar g = 0; g < BITS; g++) begin : g_rev
    assign tx_rev[g] = tx_byte[BITS-1-g];
    assign rx_rev[g] = rx_next[BITS-1-g];
  end

  assign busy       = shifting | tail;
  assign accept     = start && mode.en && !busy;
  assign leading    = !edge_idx[0];
  assign sample_now = shifting && tick && (leading == mode.lead_cap);
  assign launch_now = shifting && tick && (leading != mode.lead_cap);
  assign done       = shifting && tick && (edge_idx == LAST_EDGE);
  assign bit_in     = mode.loop ? mosi_q : miso;
  assign rx_next    = sample_now ? {rxs[BITS-2:0], bit_in} : rxs;
  assign ld         = mode.lsb ? tx_rev : tx_byte;
  assign rx_word    = mode.lsb ? rx_rev : rx_next;
  assign sck        = mode.idle_hi ^ tog;
  assign mosi       = mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shifting <= 1'b0;
      tail     <= 1'b0;
      tog      <= 1'b0;
      mosi_q   <= 1'b0;
      edge_idx <= '0;
      txs      <= '0;
      rxs      <= '0;
    end else if (!mode.en) begin
      shifting <= 1'b0;
      tail     <= 1'b0;
      tog      <= 1'b0;
      mosi_q   <= 1'b0;
      edge_idx <= '0;
    end else begin
      tail <= done;
      if (accept) begin
        shifting <= 1'b1;
        edge_idx <= '0;
        tog      <= 1'b0;
        rxs      <= '0;
        if (mode.lead_cap) begin
          mosi_q <= ld[BITS-1];
          txs    <= {ld[BITS-2:0], 1'b0};
        end else begin
          txs    <= ld;
        end
      end else if (shifting && tick) begin
        tog      <= ~tog;
        edge_idx <= edge_idx + 1'b1;
        rxs      <= rx_next;
        if (launch_now) begin
          mosi_q <= txs[BITS-1];
          txs    <= {txs[BITS-2:0], 1'b0};
        end
        if (edge_idx == LAST_EDGE) shifting <= 1'b0;
      end
    end
  end

  // R3
  frame_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shifting) |-> $past(start && mode.en));

  // R8
  busy_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(done, 2) || !$past(mode.en)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.en && !$past(mode.en)) |-> (sck == mode.idle_hi && !mosi));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  mode_t             mode_r;
  logic [BYTE_W-1:0] tx_r, rx_r, rx_word;
  logic [DIV_W-1:0]  div_r;
  logic              rdy_r, eng_busy, eng_done, go, rx_pop;

  assign go     = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL)) && reg_wdata[0];
  assign rx_pop = reg_rd && (reg_addr == ADDR_W'(OFS_RXD));
  assign irq    = rdy_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r <= '0;
      tx_r   <= '0;
      div_r  <= '0;
      rx_r   <= '0;
      rdy_r  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_W'(OFS_MODE)) mode_r <= mode_t'(reg_wdata[MODE_W-1:0]);
      if (reg_wr && reg_addr == ADDR_W'(OFS_TXD))  tx_r   <= reg_wdata;
      if (reg_wr && reg_addr == ADDR_W'(OFS_DIV))  div_r  <= reg_wdata[DIV_W-1:0];
      if (eng_done) begin
        rx_r  <= rx_word;
        rdy_r <= 1'b1;
      end else if (rx_pop) begin
        rdy_r <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(OFS_MODE): reg_rdata = 8'(mode_r);
      ADDR_W'(OFS_RXD):  reg_rdata = rx_r;
      ADDR_W'(OFS_TXD):  reg_rdata = tx_r;
      ADDR_W'(OFS_STAT): reg_rdata = {6'b0, eng_busy, rdy_r};
      ADDR_W'(OFS_DIV):  reg_rdata = 8'(div_r);
      default:           reg_rdata = 8'h00;
    endcase
  end

  spi_byte_engine #(.BITS(BYTE_W), .DIV_W(DIV_W)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_r),
    .div    (div_r),
    .start  (go),
    .tx_byte(tx_r),
    .miso   (miso),
    .sck    (sck),
    .mosi   (mosi),
    .busy   (eng_busy),
    .done   (eng_done),
    .rx_word(rx_word)
  );

  // R8
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_r) |-> $past(eng_done));

  // R9
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_r) |-> ($past(rx_pop) && !$past(eng_done)));

endmodule

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, miso = 1'b0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        irq, sck, mosi;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  // {lead_cap, idle_hi, lsb, loop} , divisor, tx, slave byte, expected rx
  localparam logic [35:0] VEC [0:7] = '{
    {4'b1000, 8'h00, 8'hA5, 8'h3C, 8'h3C},
    {4'b0000, 8'h01, 8'h96, 8'hC3, 8'hC3},
    {4'b1100, 8'h02, 8'h5A, 8'h81, 8'h81},
    {4'b0100, 8'h00, 8'h0F, 8'hE7, 8'hE7},
    {4'b1010, 8'h03, 8'h01, 8'h80, 8'h80},
    {4'b0110, 8'h01, 8'hC8, 8'h13, 8'h13},
    {4'b0001, 8'h00, 8'h6E, 8'hFF, 8'h6E},
    {4'b1101, 8'h05, 8'hB2, 8'h00, 8'hB2}
  };

  spi_byte_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic xfer(input logic [35:0] v, input int idx);
    logic       scp, ci, lsb, lp;
    logic [7:0] dv, tx, slv, exp, w, mon, d;
    int         n, toggles, t1, t3, sidx;
    logic       prev;
    string      tg;
    {scp, ci, lsb, lp, dv, tx, slv, exp} = v;
    tg = $sformatf("vec%0d", idx);
    bus_write(3'd0, {3'b0, scp, 1'b1, lsb, ci, lp});
    bus_write(3'd6, dv);
    bus_write(3'd2, tx);
    chk({tg, " R4 idle level"}, {7'b0, sck}, {7'b0, ci});
    w = lsb ? rev8(slv) : slv;
    if (scp) begin miso = w[7]; sidx = 1; end
    else     begin sidx = 0; end
    if (lp) miso = ~miso;
    prev = sck; mon = '0; toggles = 0; t1 = 0; t3 = 0; n = 0;
    bus_write(3'd3, 8'h01);
    while (1) begin
      if (sck !== prev) begin
        toggles++;
        if (toggles == 1) t1 = cyc;
        if (toggles == 3) t3 = cyc;
        if ((sck != ci) == scp) mon = {mon[6:0], mosi};
        else if (sidx < 8) begin
          miso = lp ? ~w[7-sidx] : w[7-sidx];
          sidx++;
        end
      end
      prev = sck;
      if (irq || n > 2000) break;
      @(negedge clk);
      n++;
    end
    peek(3'd4, d);
    chk({tg, " R8 status at ready"}, d, 8'h03);
    @(negedge clk);
    peek(3'd4, d);
    chk({tg, " R8 status one clock later"}, d, 8'h01);
    chk({tg, " R3 sck transitions"}, 8'(toggles), 8'd16);
    chk({tg, " R4 sck period"}, 8'(t3 - t1), 8'(4 * (dv + 1)));
    chk({tg, " R5 R6 mosi wire order"}, mon, lsb ? rev8(tx) : tx);
    bus_read(3'd1, d);
    chk({tg, " R5 R6 R7 received byte"}, d, exp);
    chk({tg, " R9 irq after read"}, {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    logic [7:0] d, old;
    int st, bad;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      peek(3'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), d, 8'h00);
    end
    chk("R1 sck/mosi/irq after reset", {5'b0, sck, mosi, irq}, 8'h00);

    // R2 register map readback
    bus_write(3'd0, 8'h17);
    bus_write(3'd6, 8'hA5);
    bus_write(3'd2, 8'h3C);
    bus_read(3'd0, d); chk("R2 mode readback", d, 8'h17);
    bus_read(3'd6, d); chk("R2 divisor readback", d, 8'hA5);
    bus_read(3'd2, d); chk("R2 transmit readback", d, 8'h3C);
    bus_read(3'd3, d); chk("R2 control reads zero", d, 8'h00);
    bus_read(3'd5, d); chk("R2 offset 5 reads zero", d, 8'h00);

    // R11 disabled port: idle high clock, mosi low, start ignored
    bus_write(3'd0, 8'h02);
    bus_write(3'd6, 8'h00);
    bus_write(3'd2, 8'hFF);
    bus_write(3'd3, 8'h01);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sck !== 1'b1 || mosi !== 1'b0) bad++;
    end
    chk("R11 sck/mosi held while disabled", 8'(bad), 8'h00);
    peek(3'd4, d);
    chk("R11 start ignored while disabled", d, 8'h00);

    // main table
    for (int i = 0; i < 8; i++) xfer(VEC[i], i);

    // R9 R10 read coinciding with completion, start and tx write while busy
    bus_write(3'd0, 8'h19);
    bus_write(3'd6, 8'h00);
    bus_write(3'd2, 8'h4D);
    bus_write(3'd3, 8'h01);
    st = cyc;
    bus_write(3'd2, 8'h7B);
    bus_write(3'd3, 8'h01);
    while (cyc != st + 31) @(negedge clk);
    addr = 3'd1; rd = 1'b1;
    #1 old = rdata;
    @(negedge clk);
    rd = 1'b0;
    chk("R9 coincident read returns previous byte", old, 8'hB2);
    peek(3'd4, d);
    chk("R9 ready kept when completion meets read", d, 8'h03);
    bus_read(3'd1, d);
    chk("R10 first frame unaffected by tx write", d, 8'h4D);
    chk("R9 irq cleared by read", {7'b0, irq}, 8'h00);
    repeat (80) @(negedge clk);
    peek(3'd4, d);
    chk("R10 start while busy ignored", d, 8'h00);
    bus_write(3'd3, 8'h01);
    bad = 0;
    while (!irq && bad < 500) begin @(negedge clk); bad++; end
    bus_read(3'd1, d);
    chk("R10 queued tx byte sent by next start", d, 8'h7B);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule